// File: doc/BRIEF.md
# Streaming 3x3 RGB Convolution Filter

This block filters a raster-ordered stream of 24-bit RGB pixels with a fixed 3x3 integer kernel. Each colour channel has its own pair of line buffers, its own 3x3 window of registers and its own arithmetic lane. Each lane multiplies the nine window pixels by the signed kernel coefficients, sums the products through a pipelined adder tree, divides by a power of two and clamps the result to an 8-bit pixel.

The kernel is given at build time with the flip already applied, so tap 0 weighs the top-left pixel of the window. A pixel whose 3x3 neighbourhood would reach past the frame edge gives no output. The output frame is therefore two columns and two rows smaller than the input. Each output carries its coordinates inside that smaller frame.

A pulse on the frame-end input puts the block back at the start of a frame. Results already inside the arithmetic pipeline still drain to the output.

Top module: `conv3x3_rgb`

## Requirements
- R1: For an input frame of IMG_W x IMG_H pixels, exactly (IMG_W-2)*(IMG_H-2) outputs are produced, in raster order. Each output has out_x from 0 to IMG_W-3 and out_y from 0 to IMG_H-3, and stands for the input pixel at column out_x+1, row out_y+1.
- R2: Per channel, the output is the sum over r,c in 0..2 of KERNEL[3*r+c] * P(out_y+r, out_x+c), where P(row, col) is the input pixel. Tap index 0 is the top-left of the window and index 8 the bottom-right. Channels occupy bits 7:0 (channel 0), 15:8 (channel 1) and 23:16 (channel 2) of both in_rgb and out_rgb, and they do not interact.
- R3: The sum is divided by 2**PRESCALE with an arithmetic right shift, before clamping.
- R4: A shifted result below 0 gives 0. A result above 255 gives 255. Any other result passes unchanged.
- R5: An output appears exactly five clock cycles after the input pixel that completes its window is accepted.
- R6: Only cycles with in_valid high advance the stream. Idle cycles between pixels do not change any result or coordinate.
- R7: frame_end high clears the window and coordinate state, so the next accepted pixel is column 0, row 0. A pixel presented in the same cycle as frame_end is dropped. Results already in the pipeline still appear.
- R8: During and directly after synchronous reset, out_valid is low.
- R9: Input pixels are unsigned. A value of 255 weighs +255 in the sum and is never treated as negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_rgb carries a pixel this cycle |
| frame_end | input | 1 | Ends the current frame and clears window and coordinate state |
| in_rgb | input | 24 | Input pixel, three 8-bit channels |
| out_valid | output | 1 | out_rgb, out_x and out_y are valid |
| out_rgb | output | 24 | Filtered pixel, same channel layout as in_rgb |
| out_x | output | OX_W | Column in the cropped output frame |
| out_y | output | OY_W | Row in the cropped output frame |

## Verification
The bench builds the block for a 6x5 frame, so each frame yields a 4x3 output and every crop boundary, including row wrap, is reached within a few dozen cycles. Its kernel has no symmetry and has signed coefficients from -4 to +15, so a tap read from the wrong row or column changes the result. PRESCALE is 2, so a negative sum passes through the shift, and a shift that loses the sign would show up as a clamp to 255 where 0 is expected. Uniform and column-striped images drive each channel to the low clamp, the high clamp and a pass-through value in the same frame.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

    localparam int PIX_W       = 8;
    localparam int COEF_W      = 5;
    localparam int PROD_W      = PIX_W + 1 + COEF_W;   // 14
    localparam int ACC_W       = PROD_W + 3;           // 17
    localparam int TAPS        = 9;
    localparam int CHANNELS    = 3;
    localparam int RGB_W       = CHANNELS * PIX_W;
    localparam int LANE_STAGES = 4;
    localparam int PIX_MAX     = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0]                pix_t;
    typedef logic [TAPS-1:0][COEF_W-1:0]     kernel_t;
    typedef pix_t [TAPS-1:0]                 win_t;
    typedef win_t [CHANNELS-1:0]             win_bank_t;

    typedef logic signed [PROD_W-1:0]        prod_t;
    typedef logic signed [PROD_W:0]          pair_t;
    typedef logic signed [PROD_W+1:0]        quad_t;
    typedef logic signed [ACC_W-1:0]         acc_t;

    // Unsigned pixel times signed coefficient, both widened to the product width.
    function automatic prod_t tap_mul(input pix_t p, input logic [COEF_W-1:0] c);
        prod_t a;
        prod_t b;
        a = prod_t'({1'b0, p});
        b = prod_t'(signed'(c));
        return a * b;
    endfunction

    function automatic pix_t clamp_pix(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/conv3x3_window.sv
module conv3x3_window
    import conv3x3_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int OX_W  = 3,
    parameter int OY_W  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            frame_end,
    input  logic [RGB_W-1:0] in_rgb,
    output win_bank_t       win_o,
    output logic            win_vld,
    output logic [OX_W-1:0] win_x,
    output logic [OY_W-1:0] win_y
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H + 1);
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_END  = RW'(IMG_H);

    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          accept;

    // Pixels beyond the last row of a frame are ignored until frame_end.
    assign accept = in_valid && !frame_end && (row < ROW_END);

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            col <= '0;
            row <= '0;
        end else if (accept) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            win_vld <= 1'b0;
            win_x   <= '0;
            win_y   <= '0;
        end else begin
            win_vld <= accept && (col >= CW'(2)) && (row >= RW'(2));
            win_x   <= OX_W'(col - CW'(2));
            win_y   <= OY_W'(row - RW'(2));
        end
    end

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        pix_t lb_up1 [IMG_W];   // previous row
        pix_t lb_up2 [IMG_W];   // row before that
        pix_t px_in;
        win_t win_q;

        assign px_in = in_rgb[ch*PIX_W +: PIX_W];

        always_ff @(posedge clk) begin
            if (accept) begin
                lb_up1[col] <= px_in;
                lb_up2[col] <= lb_up1[col];
            end
        end

        always_ff @(posedge clk) begin
            if (rst || frame_end) begin
                win_q <= '0;
            end else if (accept) begin
                for (int r = 0; r < 3; r++) begin
                    win_q[3*r]     <= win_q[3*r + 1];
                    win_q[3*r + 1] <= win_q[3*r + 2];
                end
                win_q[2] <= lb_up2[col];
                win_q[5] <= lb_up1[col];
                win_q[8] <= px_in;
            end
        end

        assign win_o[ch] = win_q;
    end

endmodule

// File: rtl/conv3x3_lane.sv
module conv3x3_lane
    import conv3x3_pkg::*;
#(
    parameter kernel_t KERNEL   = '0,
    parameter int      PRESCALE = 0
) (
    input  logic clk,
    input  win_t win_i,
    output pix_t pix_o
);

    localparam int PAIRS = TAPS / 2;

    prod_t prod_q [TAPS];
    pair_t pair_q [PAIRS + 1];
    quad_t quad_q [3];
    acc_t  total;
    acc_t  scaled;

    // Stage 1: widen and multiply
    always_ff @(posedge clk) begin
        for (int t = 0; t < TAPS; t++)
            prod_q[t] <= tap_mul(win_i[t], KERNEL[t]);
    end

    // Stage 2: pairwise sums, odd tap carried
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        always_ff @(posedge clk)
            pair_q[k] <= pair_t'(prod_q[2*k]) + pair_t'(prod_q[2*k + 1]);
    end
    always_ff @(posedge clk)
        pair_q[PAIRS] <= pair_t'(prod_q[TAPS-1]);

    // Stage 3: second adder level
    always_ff @(posedge clk) begin
        quad_q[0] <= quad_t'(pair_q[0]) + quad_t'(pair_q[1]);
        quad_q[1] <= quad_t'(pair_q[2]) + quad_t'(pair_q[3]);
        quad_q[2] <= quad_t'(pair_q[PAIRS]);
    end

    // Stage 4: final add, power-of-two scale, clamp
    always_comb begin
        total  = acc_t'(quad_q[0]) + acc_t'(quad_q[1]) + acc_t'(quad_q[2]);
        scaled = total >>> PRESCALE;
    end

    always_ff @(posedge clk)
        pix_o <= clamp_pix(scaled);

endmodule

// File: rtl/conv3x3_tag_delay.sv
module conv3x3_tag_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);

    logic         vld_q  [DEPTH];
    logic [W-1:0] data_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) vld_q[s] <= 1'b0;
                else     vld_q[s] <= vld_i;
                data_q[s] <= data_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) vld_q[s] <= 1'b0;
                else     vld_q[s] <= vld_q[s-1];
                data_q[s] <= data_q[s-1];
            end
        end
    end

    assign vld_o  = vld_q[DEPTH-1];
    assign data_o = data_q[DEPTH-1];

endmodule

// File: rtl/conv3x3_rgb.sv
module conv3x3_rgb
    import conv3x3_pkg::*;
#(
    parameter int      IMG_W    = 8,
    parameter int      IMG_H    = 6,
    parameter kernel_t KERNEL   = {5'sd0, -5'sd1, 5'sd0,
                                   -5'sd1, 5'sd5, -5'sd1,
                                   5'sd0, -5'sd1, 5'sd0},
    parameter int      PRESCALE = 0,
    localparam int     OX_W     = (IMG_W - 2 > 1) ? $clog2(IMG_W - 2) : 1,
    localparam int     OY_W     = (IMG_H - 2 > 1) ? $clog2(IMG_H - 2) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             frame_end,
    input  logic [RGB_W-1:0] in_rgb,
    output logic             out_valid,
    output logic [RGB_W-1:0] out_rgb,
    output logic [OX_W-1:0]  out_x,
    output logic [OY_W-1:0]  out_y
);

    win_bank_t       win;
    logic            win_vld;
    logic [OX_W-1:0] win_x;
    logic [OY_W-1:0] win_y;

    conv3x3_window #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .OX_W  (OX_W),
        .OY_W  (OY_W)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .frame_end (frame_end),
        .in_rgb    (in_rgb),
        .win_o     (win),
        .win_vld   (win_vld),
        .win_x     (win_x),
        .win_y     (win_y)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
        conv3x3_lane #(
            .KERNEL   (KERNEL),
            .PRESCALE (PRESCALE)
        ) u_lane (
            .clk   (clk),
            .win_i (win[ch]),
            .pix_o (out_rgb[ch*PIX_W +: PIX_W])
        );
    end

    conv3x3_tag_delay #(
        .DEPTH (LANE_STAGES),
        .W     (OX_W + OY_W)
    ) u_tag (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (win_vld),
        .data_i ({win_y, win_x}),
        .vld_o  (out_valid),
        .data_o ({out_y, out_x})
    );

endmodule

// File: rtl/conv3x3_rgb_chk.sv
module conv3x3_rgb_chk #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int OX_W  = 3,
    parameter int OY_W  = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            frame_end,
    input logic            out_valid,
    input logic [23:0]     out_rgb,
    input logic [OX_W-1:0] out_x,
    input logic [OY_W-1:0] out_y
);

    logic [OX_W-1:0] last_x;
    logic            seen;

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            seen   <= 1'b0;
            last_x <= '0;
        end else if (out_valid) begin
            seen   <= 1'b1;
            last_x <= out_x;
        end
    end

    AST_COORD_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_x) < IMG_W - 2) && (int'(out_y) < IMG_H - 2)); // R1

    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        out_valid && seen && (out_x != '0) |-> out_x == OX_W'(last_x + 1'b1)); // R1

    AST_FIVE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 5) && !$past(frame_end, 5)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid); // R8

    AST_PIX_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_rgb)); // R2

endmodule

bind conv3x3_rgb conv3x3_rgb_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .OX_W  (OX_W),
    .OY_W  (OY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .frame_end (frame_end),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_x     (out_x),
    .out_y     (out_y)
);

// File: tb/conv3x3_rgb_test.sv
module conv3x3_rgb_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 6;
    localparam int H  = 5;
    localparam int OW = W - 2;
    localparam int OH = H - 2;
    localparam int NOUT = OW * OH;
    localparam int PRESC = 2;

    // Row-major taps, index 0 = top-left
    int kc [9] = '{1, -2, 0, -3, 15, 2, 0, -1, -4};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        frame_end = 1'b0;
    logic [23:0] in_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;
    logic [1:0]  out_x;
    logic [1:0]  out_y;

    conv3x3_rgb #(
        .IMG_W    (W),
        .IMG_H    (H),
        .KERNEL   ({-5'sd4, -5'sd1, 5'sd0, 5'sd2, 5'sd15, -5'sd3, 5'sd0, -5'sd2, 5'sd1}),
        .PRESCALE (PRESC)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .frame_end (frame_end),
        .in_rgb    (in_rgb),
        .out_valid (out_valid),
        .out_rgb   (out_rgb),
        .out_x     (out_x),
        .out_y     (out_y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    int img [H][W][3];
    int got_n = 0;
    int got_rgb [64];
    int got_x   [64];
    int got_y   [64];
    int got_cyc [64];

    always @(negedge clk) begin
        if (out_valid && got_n < 64) begin
            got_rgb[got_n] = int'(out_rgb);
            got_x[got_n]   = int'(out_x);
            got_y[got_n]   = int'(out_y);
            got_cyc[got_n] = cyc;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int ref_ch(input int x, input int y, input int ch);
        int s = 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                s += kc[3*r + c] * img[y + r][x + c][ch];
        s = s >>> PRESC;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    function automatic int ref_rgb(input int x, input int y);
        return (ref_ch(x, y, 2) << 16) | (ref_ch(x, y, 1) << 8) | ref_ch(x, y, 0);
    endfunction

    task automatic drive_pixel(input int x, input int y);
        in_valid = 1'b1;
        in_rgb = {8'(img[y][x][2]), 8'(img[y][x][1]), 8'(img[y][x][0])};
    endtask

    task automatic drive_full(input bit gaps, output int c22);
        c22 = -1;
        got_n = 0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (gaps && ((x + y) % 3 == 1)) begin
                    @(negedge clk); in_valid = 1'b0; in_rgb = 24'hA5A5A5;
                    @(negedge clk); in_valid = 1'b0;
                end
                @(negedge clk);
                drive_pixel(x, y);
                if (x == 2 && y == 2) c22 = cyc;
            end
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic check_frame(input string req);
        check(got_n == NOUT, "R1 output count", got_n, NOUT);
        for (int i = 0; i < NOUT && i < got_n; i++) begin
            int ex = i % OW;
            int ey = i / OW;
            check(got_x[i] == ex && got_y[i] == ey, "R1 coordinates",
                  got_y[i] * 16 + got_x[i], ey * 16 + ex);
            check(got_rgb[i] == ref_rgb(ex, ey), req, got_rgb[i], ref_rgb(ex, ey));
        end
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic test_random();
        int c22;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                for (int ch = 0; ch < 3; ch++)
                    img[y][x][ch] = (x * 97 + y * 61 + ch * 151 + x * y * 29 + 17) % 256;
        drive_full(1'b0, c22);
        check_frame("R2 R3 R4 random frame");
        check(got_n > 0 && got_cyc[0] == c22 + 5, "R5 latency",
              (got_n > 0) ? got_cyc[0] - c22 : -1, 5);
        end_frame();
    endtask

    task automatic test_gaps();
        int c22;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                for (int ch = 0; ch < 3; ch++)
                    img[y][x][ch] = (x * 41 + y * 113 + ch * 7 + 200) % 256;
        drive_full(1'b1, c22);
        check_frame("R6 frame with idle cycles");
        end_frame();
    endtask

    task automatic test_saturate();
        int c22;
        // ch2 uniform 100 -> 8*100/4 = 200; ch1 uniform 200 -> 400 -> 255;
        // ch0 255 on even columns: even x -> -1020/4 -> 0, odd x -> 765 -> 255
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                img[y][x][2] = 100;
                img[y][x][1] = 200;
                img[y][x][0] = (x % 2 == 0) ? 255 : 0;
            end
        drive_full(1'b0, c22);
        check(got_n == NOUT, "R1 output count", got_n, NOUT);
        for (int i = 0; i < NOUT && i < got_n; i++) begin
            int ex = i % OW;
            check(((got_rgb[i] >> 16) & 255) == 200, "R3 pass-through", (got_rgb[i] >> 16) & 255, 200);
            check(((got_rgb[i] >> 8) & 255) == 255, "R4 high clamp", (got_rgb[i] >> 8) & 255, 255);
            check((got_rgb[i] & 255) == ((ex % 2) ? 255 : 0), "R4 R9 low clamp and unsigned 255",
                  got_rgb[i] & 255, (ex % 2) ? 255 : 0);
        end
        end_frame();
    endtask

    task automatic test_abort();
        int c22;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                for (int ch = 0; ch < 3; ch++)
                    img[y][x][ch] = (x * 13 + y * 77 + ch * 89 + 3) % 256;
        got_n = 0;
        // one full row plus two pixels, the last of them together with frame_end
        for (int i = 0; i < W + 2; i++) begin
            @(negedge clk);
            drive_pixel(i % W, i / W);
            if (i == W + 1) frame_end = 1'b1;
        end
        @(negedge clk); in_valid = 1'b0; frame_end = 1'b0;
        repeat (8) @(negedge clk);
        check(got_n == 0, "R7 no output from aborted frame", got_n, 0);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                for (int ch = 0; ch < 3; ch++)
                    img[y][x][ch] = (x * 59 + y * 23 + ch * 131 + 90) % 256;
        drive_full(1'b0, c22);
        check_frame("R7 clean restart after frame_end");
        end_frame();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_random();
        test_gaps();
        test_saturate();
        test_abort();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule